// File: doc/BRIEF.md
# Match/Capture Counter-Timer with PWM

This block is a general-purpose counter-timer. Its count advances on prescaled system-clock cycles or on synchronized edges of an external capture input. Four match channels compare the count against their own match values. When a channel hits, it can flag an interrupt, clear the counter or freeze it, and set, clear or toggle its own output pin. A capture path stores the current count when the capture input shows a selected edge. In PWM mode, channels 0 to 2 drive single-edge pulse-width outputs and channel 3 sets the period.

Software sets up the block through a write-only register port, one word per cycle. The count, the last captured value, the sticky interrupt flags and one level interrupt line are visible at the outputs.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset, `count_o`, `capture_o`, `match_out`, `irq_flags_o` and `irq_o` are all zero and the counter is stopped.
- R2: Register 0 holds the control bits: bit 0 is run and bit 1 is hold. While hold is 1 the count and the prescale counter are zero. While run is 0 the count keeps its value. In clock mode with run=1 and hold=0, the count rises by one once every (P+1) cycles, where P is the prescale value held in register 1.
- R3: Register 2 bits [1:0] select the count source: 0 is the system clock, 1 is rising capture edges, 2 is falling capture edges and 3 is both edges. In modes 1 to 3, each selected edge of the synchronized capture input adds one to the count while run=1 and hold=0.
- R4: A channel event occurs when the count advances while it equals that channel's match value (registers 8 to 11 for channels 0 to 3). On an event, the channel's output follows its 2-bit action in register 5 bits [2i+1:2i]: 0 leaves it unchanged, 1 drives it low, 2 drives it high and 3 toggles it.
- R5: Register 3 has three bit groups: interrupt enables in bits [3:0], clear-on-match in bits [7:4] and stop-on-match in bits [11:8]. On an event with clear-on-match set, the next count is 0. On an event with stop-on-match set, the count keeps its value and run drops to 0. When both are set, the count still becomes 0 and the counter stops.
- R6: Register 4 sets up capture: bit 0 selects rising edges, bit 1 selects falling edges and bit 2 enables the capture interrupt. The capture input passes through two synchronizer flops. A selected edge loads the count into `capture_o` two clock edges after the input changes, and edges that are not selected have no effect.
- R7: Register 6 bits [2:0] put channels 0 to 2 into PWM mode. A channel in PWM mode outputs 1 when its match value is 0, outputs 0 when its match value is above channel 3's match value, and otherwise outputs 1 exactly while count >= its match value.
- R8: While any PWM bit is set, a channel 3 event clears the count, whatever clear-on-match is set to.
- R9: `irq_flags_o` bits [3:0] latch channel events whose interrupt enable is set, and bit 4 latches capture events when the capture interrupt is enabled. A flag stays set until a write to register 7 has a 1 in its bit position, and a set in the same cycle wins over the clear. `irq_o` is 1 exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write data |
| cap_in | input | 1 | Asynchronous capture / count-edge input |
| match_out | output | 4 | Channel output pins |
| count_o | output | 32 | Current count |
| capture_o | output | 32 | Last captured count |
| irq_flags_o | output | 5 | Sticky interrupt flags |
| irq_o | output | 1 | Level interrupt, OR of the flags |

## Verification
A bad prescale or tick state shows up on `count_o` within one count period, as a missing or extra increment. A wrong output-pin state shows on `match_out` at the next event of that channel, or at once in PWM mode, because the PWM level is decoded from the count with no register in between. A synchronizer that is off by one stage shows as a capture value off by one count step, and a flag that is lost or set by mistake shows on `irq_o` in the same cycle. The bench model predicts every output in every clock.

// File: rtl/mtmr_pkg.sv
// Package: shared encodings and register indices of the match timer.
// Assumes a 4-bit register index.
package mtmr_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } match_act_e;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } cnt_src_e;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC   = 4'd1;
    localparam logic [ADDR_W-1:0] A_SRC     = 4'd2;
    localparam logic [ADDR_W-1:0] A_MCTRL   = 4'd3;
    localparam logic [ADDR_W-1:0] A_CAPCTRL = 4'd4;
    localparam logic [ADDR_W-1:0] A_OUTACT  = 4'd5;
    localparam logic [ADDR_W-1:0] A_PWM     = 4'd6;
    localparam logic [ADDR_W-1:0] A_IRQCLR  = 4'd7;
    localparam int                MR_BASE   = 8;
endpackage

// File: rtl/mtmr_edge_sync.sv
// Module: synchronizes an asynchronous input through STAGES flops and
// flags rising and falling edges of the synchronized level.
// Assumes STAGES >= 2. The edge pulses are combinational, one cycle wide.
module mtmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    // Shift register: sync stages plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d};
    end

    // Edge decode on the synchronized level against its previous value.
    always_comb begin
        rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
        fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
    end
endmodule

// File: rtl/mtmr_counter.sv
// Module: prescaler and main count register.
// Assumes clr_req and stop_req are only meaningful while tick_o is high.
module mtmr_counter
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  cnt_src_e         src,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] presc,
    input  logic             clr_req,
    input  logic             stop_req,
    output logic [CNT_W-1:0] tc_o,
    output logic             tick_o
);
    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] tc_q;
    logic             edge_hit;
    logic             pc_wrap;

    // Tick source: prescaler wrap in clock mode, a selected edge otherwise.
    always_comb begin
        pc_wrap = (pc_q >= presc);
        unique case (src)
            SRC_RISE: edge_hit = rise;
            SRC_FALL: edge_hit = fall;
            SRC_BOTH: edge_hit = rise | fall;
            default:  edge_hit = 1'b0;
        endcase
        tick_o = run && !hold && ((src == SRC_CLK) ? pc_wrap : edge_hit);
    end

    // Prescale counter: runs only in clock mode while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)                pc_q <= '0;
        else if (run && src == SRC_CLK)    pc_q <= pc_wrap ? '0 : pc_q + 1'b1;
    end

    // Count register: clear has priority, stop freezes, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)  tc_q <= '0;
        else if (tick_o) begin
            if (clr_req)       tc_q <= '0;
            else if (!stop_req) tc_q <= tc_q + 1'b1;
        end
    end

    assign tc_o = tc_q;

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (tc_q == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !clr_req && !stop_req) |=> (tc_q == $past(tc_q) + 1'b1));
endmodule

// File: rtl/mtmr_match_chan.sv
// Module: one match channel: compare, event, output action and optional
// single-edge PWM level. Assumes period is the period channel's value.
module mtmr_match_chan
    import mtmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter bit PWM_CAPABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tc,
    input  logic [CNT_W-1:0] mr,
    input  logic [CNT_W-1:0] period,
    input  logic             tick,
    input  match_act_e       act,
    input  logic             pwm_sel,
    output logic             evt_o,
    output logic             pin_o
);
    logic ext_q;
    logic pwm_lvl;

    // Event: the count advances while sitting on the match value.
    assign evt_o = tick && (tc == mr);

    // External output state updated by the configured action.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else if (evt_o) begin
            unique case (act)
                ACT_LOW:    ext_q <= 1'b0;
                ACT_HIGH:   ext_q <= 1'b1;
                ACT_TOGGLE: ext_q <= ~ext_q;
                default:    ext_q <= ext_q;
            endcase
        end
    end

    // Single-edge PWM level decoded from the count.
    always_comb begin
        if (mr == '0)          pwm_lvl = 1'b1;
        else if (mr > period)  pwm_lvl = 1'b0;
        else                   pwm_lvl = (tc >= mr);
    end

    // Pin select: only PWM-capable channels may leave external mode.
    generate
        if (PWM_CAPABLE) begin : g_pwm
            assign pin_o = pwm_sel ? pwm_lvl : ext_q;
        end else begin : g_ext
            assign pin_o = (pwm_sel & 1'b0) | (pwm_lvl & 1'b0) | ext_q;
        end
    endgenerate

    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && act == ACT_TOGGLE) |=> (ext_q != $past(ext_q)));

    a_r4_high: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && act == ACT_HIGH) |=> ext_q);
endmodule

// File: rtl/match_timer.sv
// Module: top of the match/capture counter-timer. Holds the register file,
// capture register and sticky flags, and ties the channels to the counter.
// Assumes CNT_W <= 32, NUM_MATCH <= 8 and the register port writes one word per cycle.
module match_timer
    import mtmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NUM_MATCH   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 cap_in,
    output logic [NUM_MATCH-1:0] match_out,
    output logic [CNT_W-1:0]     count_o,
    output logic [CNT_W-1:0]     capture_o,
    output logic [NUM_MATCH:0]   irq_flags_o,
    output logic                 irq_o
);
    localparam int NUM_PWM   = NUM_MATCH - 1;
    localparam int FLAG_W    = NUM_MATCH + 1;
    localparam int PERIOD_CH = NUM_MATCH - 1;

    logic                 run_q, hold_q;
    logic [CNT_W-1:0]     presc_q;
    cnt_src_e             src_q;
    logic [NUM_MATCH-1:0] mirq_q, mrst_q, mstop_q;
    logic                 cap_rise_q, cap_fall_q, cap_irq_q;
    match_act_e           act_q [NUM_MATCH];
    logic [NUM_PWM-1:0]   pwm_q;
    logic [CNT_W-1:0]     mr_q [NUM_MATCH];
    logic [FLAG_W-1:0]    flags_q;
    logic [CNT_W-1:0]     cap_q;

    logic                 rise, fall, tick, cap_evt, clr_req, stop_hit;
    logic [CNT_W-1:0]     tc;
    logic [NUM_MATCH-1:0] evt, pwm_sel, pwm_force;
    logic [FLAG_W-1:0]    flag_set, flag_clr;

    mtmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cap_in), .rise_o(rise), .fall_o(fall));

    mtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_q), .hold(hold_q), .src(src_q),
        .rise(rise), .fall(fall), .presc(presc_q), .clr_req(clr_req),
        .stop_req(stop_hit), .tc_o(tc), .tick_o(tick));

    assign pwm_sel   = {1'b0, pwm_q};
    assign pwm_force = {|pwm_q, {NUM_PWM{1'b0}}};

    generate
        for (genvar i = 0; i < NUM_MATCH; i++) begin : g_ch
            mtmr_match_chan #(.CNT_W(CNT_W), .PWM_CAPABLE(i < NUM_PWM)) u_ch (
                .clk(clk), .rst_n(rst_n), .tc(tc), .mr(mr_q[i]),
                .period(mr_q[PERIOD_CH]), .tick(tick), .act(act_q[i]),
                .pwm_sel(pwm_sel[i]), .evt_o(evt[i]), .pin_o(match_out[i]));
        end
    endgenerate

    // Match side effects and capture/flag events.
    always_comb begin
        clr_req  = |(evt & (mrst_q | pwm_force));
        stop_hit = |(evt & mstop_q);
        cap_evt  = (rise & cap_rise_q) | (fall & cap_fall_q);
        flag_set = {cap_evt & cap_irq_q, evt & mirq_q};
        flag_clr = (wr_en && wr_addr == A_IRQCLR) ? wr_data[FLAG_W-1:0] : '0;
    end

    // Register file writes; a stop-on-match overrides a same-cycle run write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; hold_q <= 1'b0; presc_q <= '0; src_q <= SRC_CLK;
            mirq_q <= '0; mrst_q <= '0; mstop_q <= '0; pwm_q <= '0;
            cap_rise_q <= 1'b0; cap_fall_q <= 1'b0; cap_irq_q <= 1'b0;
            for (int i = 0; i < NUM_MATCH; i++) begin
                act_q[i] <= ACT_NONE;
                mr_q[i]  <= '0;
            end
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    A_CTRL:    begin run_q <= wr_data[0]; hold_q <= wr_data[1]; end
                    A_PRESC:   presc_q <= wr_data[CNT_W-1:0];
                    A_SRC:     src_q <= cnt_src_e'(wr_data[1:0]);
                    A_MCTRL: begin
                        mirq_q  <= wr_data[NUM_MATCH-1:0];
                        mrst_q  <= wr_data[2*NUM_MATCH-1:NUM_MATCH];
                        mstop_q <= wr_data[3*NUM_MATCH-1:2*NUM_MATCH];
                    end
                    A_CAPCTRL: begin
                        cap_rise_q <= wr_data[0];
                        cap_fall_q <= wr_data[1];
                        cap_irq_q  <= wr_data[2];
                    end
                    A_OUTACT:
                        for (int i = 0; i < NUM_MATCH; i++)
                            act_q[i] <= match_act_e'(wr_data[2*i +: 2]);
                    A_PWM:     pwm_q <= wr_data[NUM_PWM-1:0];
                    default:   ;
                endcase
            end
            for (int i = 0; i < NUM_MATCH; i++)
                if (wr_en && wr_addr == ADDR_W'(MR_BASE + i))
                    mr_q[i] <= wr_data[CNT_W-1:0];
            if (stop_hit) run_q <= 1'b0;
        end
    end

    // Sticky flags: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    // Capture register: loads the count on a selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= tc;
    end

    assign count_o     = tc;
    assign capture_o   = cap_q;
    assign irq_flags_o = flags_q;
    assign irq_o       = |flags_q;

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags_q) & ~$past(flag_clr)) & ~flags_q) == '0));

    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(tc)));

    a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !run_q);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_req) |=> (count_o == '0));

    a_r8_period: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (|pwm_q) && tc == mr_q[PERIOD_CH]) |=> (count_o == '0));
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cap_in = 1'b0;
    logic [3:0]  match_out;
    logic [31:0] count_o, capture_o;
    logic [4:0]  irq_flags_o;
    logic        irq_o;

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_in(cap_in), .match_out(match_out),
        .count_o(count_o), .capture_o(capture_o), .irq_flags_o(irq_flags_o),
        .irq_o(irq_o));

    // ---------------- reference model ----------------
    bit          m_run, m_hold, m_crise, m_cfall, m_cirq;
    int unsigned m_presc, m_src, m_pc, m_tc, m_cap;
    bit [3:0]    m_mirq, m_mrst, m_mstop, m_ext;
    bit [2:0]    m_pwm;
    bit [4:0]    m_flags;
    int unsigned m_act [4];
    int unsigned m_mr  [4];
    bit          samp  [$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit rise, fall, ehit, tick, clr, stop, cevt;
        bit [3:0] evt;
        bit [4:0] setm, clrm;
        if (!rst_n) begin
            m_run = 0; m_hold = 0; m_crise = 0; m_cfall = 0; m_cirq = 0;
            m_presc = 0; m_src = 0; m_pc = 0; m_tc = 0; m_cap = 0;
            m_mirq = 0; m_mrst = 0; m_mstop = 0; m_ext = 0; m_pwm = 0; m_flags = 0;
            for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_mr[i] = 0; end
            samp = '{0, 0, 0};
        end else begin
            rise = samp[1] && !samp[2];
            fall = !samp[1] && samp[2];
            ehit = (m_src == 1 && rise) || (m_src == 2 && fall) || (m_src == 3 && (rise || fall));
            tick = m_run && !m_hold && (m_src == 0 ? (m_pc >= m_presc) : ehit);
            clr = 0; stop = 0;
            for (int i = 0; i < 4; i++) begin
                evt[i] = tick && (m_tc == m_mr[i]);
                if (evt[i] && (m_mrst[i] || (i == 3 && m_pwm != 0))) clr = 1;
                if (evt[i] && m_mstop[i]) stop = 1;
            end
            cevt = (rise && m_crise) || (fall && m_cfall);
            setm = {cevt && m_cirq, evt & m_mirq};
            clrm = (wr_en && wr_addr == 7) ? wr_data[4:0] : 5'd0;
            if (cevt) m_cap = m_tc;
            m_flags = (m_flags & ~clrm) | setm;
            for (int i = 0; i < 4; i++)
                if (evt[i])
                    case (m_act[i])
                        1: m_ext[i] = 0;
                        2: m_ext[i] = 1;
                        3: m_ext[i] = !m_ext[i];
                        default: ;
                    endcase
            if (m_hold) m_pc = 0;
            else if (m_run && m_src == 0) m_pc = (m_pc >= m_presc) ? 0 : m_pc + 1;
            if (m_hold) m_tc = 0;
            else if (tick) m_tc = clr ? 0 : (stop ? m_tc : m_tc + 1);
            if (wr_en) begin
                case (wr_addr)
                    0: begin m_run = wr_data[0]; m_hold = wr_data[1]; end
                    1: m_presc = wr_data;
                    2: m_src = wr_data[1:0];
                    3: begin m_mirq = wr_data[3:0]; m_mrst = wr_data[7:4]; m_mstop = wr_data[11:8]; end
                    4: begin m_crise = wr_data[0]; m_cfall = wr_data[1]; m_cirq = wr_data[2]; end
                    5: for (int i = 0; i < 4; i++) m_act[i] = wr_data[2*i +: 2];
                    6: m_pwm = wr_data[2:0];
                    8, 9, 10, 11: m_mr[wr_addr - 8] = wr_data;
                    default: ;
                endcase
            end
            if (stop) m_run = 0;
            samp = {cap_in, samp[0], samp[1]};
        end
    end

    function automatic bit exp_pin(int i);
        if (i < 3 && m_pwm[i]) begin
            if (m_mr[i] == 0) return 1'b1;
            if (m_mr[i] > m_mr[3]) return 1'b0;
            return m_tc >= m_mr[i];
        end
        return m_ext[i];
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, between clock edges.
    always begin
        @(posedge clk);
        #5;
        chk("R2", "count", count_o, m_tc);
        chk("R6", "capture", capture_o, m_cap);
        chk("R9", "flags", {27'd0, irq_flags_o}, {27'd0, m_flags});
        chk("R9", "irq", {31'd0, irq_o}, {31'd0, m_flags != 0});
        for (int i = 0; i < 4; i++)
            chk("R4/R7", "pin", {31'd0, match_out[i]}, {31'd0, exp_pin(i)});
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            cap_in = 1'b1; idle(3);
            cap_in = 1'b0; idle(3);
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: got=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        int errs;
        bit  p;
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "count after reset", count_o, 0);
        chk("R1", "pins after reset", {28'd0, match_out}, 0);
        chk("R1", "irq after reset", {31'd0, irq_o}, 0);

        // R2: clock mode, disable, hold
        wr(4'd1, 2); wr(4'd0, 1); idle(20);
        chk("R2", "count advanced", {31'd0, count_o > 0}, 1);
        wr(4'd0, 0); snap = count_o; idle(6);
        chk("R2", "disabled count holds", count_o, snap);
        wr(4'd0, 3); idle(2);
        chk("R2", "hold zeroes count", count_o, 0);
        idle(5);
        chk("R2", "hold keeps zero", count_o, 0);

        // R5 clear-on-match, R9 flags
        wr(4'd1, 0); wr(4'd8, 5); wr(4'd3, 32'h11); wr(4'd0, 1);
        errs = 0;
        for (int k = 0; k < 30; k++) begin @(negedge clk); if (count_o > 5) errs++; end
        chk("R5", "count wraps at match", errs, 0);
        chk("R9", "match flag set", {31'd0, irq_flags_o[0]}, 1);
        chk("R9", "irq high", {31'd0, irq_o}, 1);
        wr(4'd0, 0); wr(4'd7, 1); idle(1);
        chk("R9", "flag cleared", {27'd0, irq_flags_o}, 0);
        chk("R9", "irq low", {31'd0, irq_o}, 0);

        // R4 output actions
        wr(4'd0, 2); wr(4'd3, 32'h80); wr(4'd11, 6); wr(4'd8, 2); wr(4'd9, 3); wr(4'd10, 4);
        wr(4'd5, 32'h1E); wr(4'd0, 1); idle(25);
        chk("R4", "drive-high pin", {31'd0, match_out[0]}, 1);
        p = match_out[1]; idle(7);
        chk("R4", "toggle pin per period", {31'd0, match_out[1]}, {31'd0, !p});

        // R5 stop-on-match and clear priority
        wr(4'd0, 2); wr(4'd3, 32'h400); wr(4'd0, 1); idle(15);
        chk("R5", "stop at match", count_o, 4);
        idle(5);
        chk("R5", "stays stopped", count_o, 4);
        wr(4'd0, 2); wr(4'd3, 32'h220); wr(4'd0, 1); idle(10);
        errs = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); if (count_o != 0) errs++; end
        chk("R5", "clear wins then stop", errs, 0);

        // R6 capture
        wr(4'd0, 2); wr(4'd3, 0); wr(4'd4, 5); wr(4'd0, 1); idle(10);
        cap_in = 1'b1; idle(2); snap = count_o; idle(4);
        chk("R6", "capture value", capture_o, snap);
        chk("R6", "capture flag", {31'd0, irq_flags_o[4]}, 1);
        cap_in = 1'b0; idle(6);
        chk("R6", "falling edge ignored", capture_o, snap);
        wr(4'd4, 2); cap_in = 1'b1; idle(4); cap_in = 1'b0; idle(2); snap = count_o; idle(4);
        chk("R6", "falling edge capture", capture_o, snap);

        // R3 capture-clocked counting
        wr(4'd0, 2); wr(4'd2, 1); wr(4'd0, 1); pulses(5); idle(6);
        chk("R3", "rising edges counted", count_o, 5);
        wr(4'd0, 2); wr(4'd2, 3); wr(4'd0, 1); pulses(2); idle(6);
        chk("R3", "both edges counted", count_o, 4);

        // R7 PWM, R8 period from channel 3
        wr(4'd0, 2); wr(4'd2, 0); wr(4'd4, 0); wr(4'd11, 9); wr(4'd8, 0);
        wr(4'd9, 4); wr(4'd10, 20); wr(4'd6, 7); wr(4'd0, 1);
        errs = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (match_out[0] !== 1'b1) errs++;
            if (match_out[2] !== 1'b0) errs++;
            if (match_out[1] !== (count_o >= 4)) errs++;
        end
        chk("R7", "pwm levels", errs, 0);
        errs = 0;
        for (int k = 0; k < 30; k++) begin @(negedge clk); if (count_o > 9) errs++; end
        chk("R8", "pwm period", errs, 0);

        idle(3);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule